// File: doc/BRIEF.md
# Prescaled Programmable Interrupt Timer

This block is an interrupt timer for a cartridge. It holds an 8-bit main counter behind an 8-bit prescaler. Both registers step in one direction set by software. That direction is up, down, or stopped. Each prescaler step comes from one of four event sources. The first is a per-CPU-cycle strobe. The second is a scanline strobe that is worth eight steps. The third is a change on the video address bus that is worth two steps. The fourth source is reserved and produces no steps at all.

The prescaler can be used at its full 8 bits or only through its low 3 bits. Each time the masked prescaler value rolls over, the main counter takes one step. When the main counter wraps while the timer is enabled, a level interrupt goes high. It stays high until software acknowledges it. Software sets up the timer through eight write offsets. Values loaded into the prescaler and into the main counter are first XORed with a key that software programs.

Top module: `irqtmr_top`

## Requirements
- R1: Mode bits 7:6 select the direction: 01 counts up and 10 counts down. With 00 or 11 neither counter moves, and both keep their values for later counting.
- R2: With mode bits 1:0 = 0, each cycle in which `cpu_cycle` is high applies exactly one prescaler step in that cycle. Cycles without the strobe apply none.
- R3: With mode bits 1:0 = 1, a one-cycle `scanline` pulse gives eight steps. These land on the eight clock edges that follow the edge that captured the pulse.
- R4: With mode bits 1:0 = 2, a `vaddr` value that differs from the address captured on the previous edge gives two steps on the following edges. An unchanged address gives no steps.
- R5: With mode bits 1:0 = 3, no event of any kind moves the counters.
- R6: Mode bit 2 set masks the prescaler to its low 3 bits, so one main step occurs every 8 prescaler steps. Bit 2 clear uses all 8 bits, so one main step occurs every 256 prescaler steps.
- R7: Counting up, the main counter steps when the masked prescaler becomes zero. Counting down, it steps when the masked prescaler becomes equal to the mask.
- R8: The interrupt sets when the main counter wraps to 0x00 going up, or to 0xFF going down, but only if the timer is enabled. A wrap while disabled leaves `irq` low.
- R9: Offset 6 stores a key. A write to offset 4 loads the prescaler, and a write to offset 5 loads the main counter, each with the written byte XOR the key.
- R10: Offset 0 copies data bit 0 into the enable, and also clears the interrupt when that bit is 0. Offset 2 disables and clears. Offset 3 enables and does not clear. Offset 1 writes the mode.
- R11: A write to offset 7 is accepted and has no effect on counting.
- R12: `irq` is a level that holds until cleared. Reset drives it low and zeroes the prescaler, the main counter, the key, the enable and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| cpu_cycle | input | 1 | One pulse per CPU cycle |
| scanline | input | 1 | One pulse per scanline event |
| vaddr | input | 14 | Video address bus |
| irq | output | 1 | Level interrupt request |

## Verification
A register write takes effect on the edge that captures it. A CPU-cycle step is applied on the same edge as the strobe, so `irq` is visible after the edge of the final required step. For scanline and address events, the first edge only records the pending steps, and the steps then land one per edge afterwards. The bench counts clock edges from the first step edge and samples `irq` at the falling edge after each one. It requires the first high sample to fall exactly on the edge count computed from the loaded values, the mask and the direction.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

    localparam int CNT_W       = 8;
    localparam int SHORT_W     = 3;
    localparam int LINE_TICKS  = 8;
    localparam int ADDR_TICKS  = 2;
    localparam int PEND_W      = 5;

    localparam int MODE_DIR_HI = 7;
    localparam int MODE_DIR_LO = 6;
    localparam int MODE_SHORT  = 2;

    typedef enum logic [1:0] {
        DIR_HOLD_A = 2'b00,
        DIR_UP     = 2'b01,
        DIR_DOWN   = 2'b10,
        DIR_HOLD_B = 2'b11
    } dir_e;

    typedef enum logic [1:0] {
        SRC_CPU   = 2'd0,
        SRC_LINE  = 2'd1,
        SRC_VADDR = 2'd2,
        SRC_WRITE = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        OFF_ENA  = 3'd0,
        OFF_MODE = 3'd1,
        OFF_DIS  = 3'd2,
        OFF_EN   = 3'd3,
        OFF_PRE  = 3'd4,
        OFF_CNT  = 3'd5,
        OFF_KEY  = 3'd6,
        OFF_ADJ  = 3'd7
    } off_e;

    function automatic logic is_moving(dir_e d);
        return (d == DIR_UP) || (d == DIR_DOWN);
    endfunction

    function automatic logic is_burst_src(src_e s);
        return (s == SRC_LINE) || (s == SRC_VADDR);
    endfunction

endpackage

// File: rtl/irqtmr_regs.sv
module irqtmr_regs
    import irqtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   wr_off,
    input  logic [W-1:0] wr_data,
    output dir_e         dir,
    output logic         short_pre,
    output src_e         src,
    output logic         en,
    output logic         ack,
    output logic         load_pre,
    output logic         load_cnt,
    output logic [W-1:0] load_val
);

    off_e         off;
    logic [W-1:0] key;

    always_comb begin
        off      = off_e'(wr_off);
        ack      = wr_en && ((off == OFF_DIS) || (off == OFF_ENA && !wr_data[0]));
        load_pre = wr_en && (off == OFF_PRE);
        load_cnt = wr_en && (off == OFF_CNT);
        load_val = wr_data ^ key;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key       <= '0;
            en        <= 1'b0;
            dir       <= DIR_HOLD_A;
            short_pre <= 1'b0;
            src       <= SRC_CPU;
        end else if (wr_en) begin
            unique case (off)
                OFF_ENA:  en <= wr_data[0];
                OFF_MODE: begin
                    dir       <= dir_e'(wr_data[MODE_DIR_HI:MODE_DIR_LO]);
                    short_pre <= wr_data[MODE_SHORT];
                    src       <= src_e'(wr_data[1:0]);
                end
                OFF_DIS:  en  <= 1'b0;
                OFF_EN:   en  <= 1'b1;
                OFF_KEY:  key <= wr_data;
                default:  ;
            endcase
        end
    end

    assert_enable_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_EN) |=> en);
    assert_disable_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && off == OFF_DIS) |=> !en);

endmodule

// File: rtl/irqtmr_ticks.sv
module irqtmr_ticks
    import irqtmr_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  src_e          src,
    input  logic          cpu_cycle,
    input  logic          scanline,
    input  logic [AW-1:0] vaddr,
    output logic          tick
);

    localparam logic [PEND_W:0] PEND_MAX = (PEND_W+1)'((1 << PEND_W) - 1);

    logic [PEND_W-1:0] pend;
    logic [PEND_W-1:0] pend_n;
    logic [PEND_W:0]   pend_sum;
    logic [PEND_W:0]   add;
    logic [AW-1:0]     last_addr;

    always_comb begin
        add = '0;
        unique case (src)
            SRC_LINE:  if (scanline)           add = (PEND_W+1)'(LINE_TICKS);
            SRC_VADDR: if (vaddr != last_addr) add = (PEND_W+1)'(ADDR_TICKS);
            default:   ;
        endcase
        pend_sum = {1'b0, pend} - {{PEND_W{1'b0}}, (pend != '0)} + add;
        pend_n   = (pend_sum > PEND_MAX) ? PEND_MAX[PEND_W-1:0] : pend_sum[PEND_W-1:0];
        if (src == SRC_CPU) tick = cpu_cycle;
        else                tick = is_burst_src(src) && (pend != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            last_addr <= '0;
        end else begin
            pend <= is_burst_src(src) ? pend_n : '0;
            if (src == SRC_VADDR) last_addr <= vaddr;
        end
    end

    assert_line_burst_R3: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_LINE && scanline && pend == '0) |=> (pend == PEND_W'(LINE_TICKS)));
    assert_same_addr_R4: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_VADDR && vaddr == last_addr && pend == '0) |=> (pend == '0));
    assert_write_src_R5: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_WRITE) |-> !tick);

endmodule

// File: rtl/irqtmr_count.sv
module irqtmr_count
    import irqtmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_e         dir,
    input  logic         short_pre,
    input  logic         tick,
    input  logic         en,
    input  logic         ack,
    input  logic         load_pre,
    input  logic         load_cnt,
    input  logic [W-1:0] load_val,
    output logic         irq
);

    localparam logic [W-1:0] SHORT_MASK = {{(W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};

    logic [W-1:0] pre, cnt, pre_n, cnt_n, mask;
    logic         carry, wrap;

    always_comb begin
        mask  = short_pre ? SHORT_MASK : '1;
        pre_n = pre;
        cnt_n = cnt;
        carry = 1'b0;
        wrap  = 1'b0;
        if (tick) begin
            unique case (dir)
                DIR_UP: begin
                    pre_n = pre + 1'b1;
                    carry = (pre_n & mask) == '0;
                end
                DIR_DOWN: begin
                    pre_n = pre - 1'b1;
                    carry = (pre_n & mask) == mask;
                end
                default: ;
            endcase
        end
        if (carry) begin
            if (dir == DIR_UP) begin
                cnt_n = cnt + 1'b1;
                wrap  = cnt_n == '0;
            end else begin
                cnt_n = cnt - 1'b1;
                wrap  = cnt_n == '1;
            end
        end
        if (load_pre) pre_n = load_val;
        if (load_cnt) begin
            cnt_n = load_val;
            wrap  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre <= '0;
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            pre <= pre_n;
            cnt <= cnt_n;
            irq <= ack ? 1'b0 : (irq || (wrap && en));
        end
    end

    assert_stopped_R1: assert property (@(posedge clk) disable iff (rst)
        (!is_moving(dir) && !load_pre && !load_cnt) |=> ($stable(pre) && $stable(cnt)));
    assert_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (!irq && !en) |=> !irq);
    assert_level_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack) |=> irq);
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !irq);

endmodule

// File: rtl/irqtmr_top.sv
module irqtmr_top
    import irqtmr_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_off,
    input  logic [W-1:0]  wr_data,
    input  logic          cpu_cycle,
    input  logic          scanline,
    input  logic [AW-1:0] vaddr,
    output logic          irq
);

    dir_e         dir;
    src_e         src;
    logic         short_pre, en, ack, load_pre, load_cnt, tick;
    logic [W-1:0] load_val;

    irqtmr_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .dir(dir), .short_pre(short_pre), .src(src), .en(en), .ack(ack),
        .load_pre(load_pre), .load_cnt(load_cnt), .load_val(load_val)
    );

    irqtmr_ticks #(.AW(AW)) u_ticks (
        .clk(clk), .rst(rst), .src(src), .cpu_cycle(cpu_cycle),
        .scanline(scanline), .vaddr(vaddr), .tick(tick)
    );

    irqtmr_count #(.W(W)) u_count (
        .clk(clk), .rst(rst), .dir(dir), .short_pre(short_pre), .tick(tick),
        .en(en), .ack(ack), .load_pre(load_pre), .load_cnt(load_cnt),
        .load_val(load_val), .irq(irq)
    );

endmodule

// File: tb/irqtmr_top_tb.sv
`timescale 1ns/1ps
module irqtmr_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_off = '0;
    logic [7:0]  wr_data = '0;
    logic        cpu_cycle = 1'b0;
    logic        scanline = 1'b0;
    logic [13:0] vaddr = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    irqtmr_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .cpu_cycle(cpu_cycle), .scanline(scanline), .vaddr(vaddr), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int off, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off[2:0]; wr_data = data[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int exp_up(input int p, input int c, input int m);
        return (((m - (p & m)) & m) + 1) + ((255 - c) & 255) * (m + 1);
    endfunction

    function automatic int exp_dn(input int p, input int c, input int m);
        return (p & m) + 1 + c * (m + 1);
    endfunction

    // raw values are XORed with key inside the design
    task automatic cfg(input int mode, input int key, input int praw, input int craw);
        wr(6, key); wr(4, praw); wr(5, craw); wr(1, mode); wr(2, 0); wr(3, 0);
    endtask

    task automatic run_count(input int exp, input string tag);
        int first = 0;
        @(negedge clk);
        cpu_cycle = 1'b1;
        for (int k = 1; k <= exp + 3; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq && first == 0) first = k;
        end
        cpu_cycle = 1'b0;
        check(first == exp, tag, first, exp);
    endtask

    initial begin
        int first;
        idle(3);
        check(irq == 1'b0, "R12 irq low in reset", irq, 0);
        rst = 1'b0;
        idle(2);
        check(irq == 1'b0, "R12 irq low after reset", irq, 0);

        // R12: reset zeroes both counters; up, 3-bit mask
        wr(1, 8'h44); wr(3, 0);
        run_count(exp_up(0, 0, 7), "R12 reset values count");

        // R6/R7/R2 sweep of the 3-bit prescaler, both directions
        for (int d = 0; d < 2; d++)
            for (int p = 0; p < 8; p++)
                for (int ci = 0; ci < 3; ci++) begin
                    int c = (ci == 0) ? 8'hFF : (ci == 1) ? 8'hFE : 8'h80;
                    cfg(d == 0 ? 8'h44 : 8'h84, 0, p, c);
                    run_count(d == 0 ? exp_up(p, c, 7) : exp_dn(p, c, 7),
                              d == 0 ? "R7 up short sweep" : "R7 down short sweep");
                end

        // R6: full 8-bit prescaler
        cfg(8'h40, 0, 8'hFE, 8'hFF); run_count(exp_up(8'hFE, 8'hFF, 255), "R6 up long near");
        cfg(8'h40, 0, 8'h00, 8'hFF); run_count(exp_up(0, 8'hFF, 255), "R6 up long full");
        cfg(8'h80, 0, 8'h05, 8'h00); run_count(exp_dn(5, 0, 255), "R6 down long near");
        cfg(8'h80, 0, 8'hFF, 8'h01); run_count(exp_dn(8'hFF, 1, 255), "R6 down long two");
        // upper prescaler bits ignored by the 3-bit mask
        cfg(8'h44, 0, 8'hF9, 8'hFF); run_count(exp_up(8'hF9, 8'hFF, 7), "R6 short ignores high bits");

        // R9: XOR key applied to both loads
        cfg(8'h44, 8'h5A, 8'h5A ^ 3, 8'h5A ^ 8'hFE);
        run_count(exp_up(3, 8'hFE, 7), "R9 xor key up");
        cfg(8'h84, 8'hC3, 8'h01, 8'h02);
        run_count(exp_dn(8'h01 ^ 8'hC3, 8'h02 ^ 8'hC3, 7), "R9 xor key down");

        // R11: offset 7 has no effect
        cfg(8'h44, 0, 2, 8'hFE); wr(7, 8'hFF); wr(7, 8'h00);
        run_count(exp_up(2, 8'hFE, 7), "R11 adjust byte ignored");

        // R2: strobe every other cycle, 3 ticks needed -> edge 5
        cfg(8'h44, 0, 5, 8'hFF);
        first = 0;
        for (int k = 1; k <= 8; k++) begin
            cpu_cycle = k[0];
            @(posedge clk); @(negedge clk);
            if (irq && first == 0) first = k;
        end
        cpu_cycle = 1'b0;
        check(first == 5, "R2 sparse cpu strobe", first, 5);

        // R12 level hold, R10 offsets
        cfg(8'h44, 0, 7, 8'hFF); run_count(1, "R8 single tick wrap");
        idle(30);
        check(irq == 1'b1, "R12 level holds", irq, 1);
        wr(3, 0);
        check(irq == 1'b1, "R10 offset3 does not clear", irq, 1);
        wr(0, 1);
        check(irq == 1'b1, "R10 offset0 bit0=1 does not clear", irq, 1);
        wr(0, 0);
        check(irq == 1'b0, "R10 offset0 bit0=0 clears", irq, 0);
        // R8: wrap while disabled
        wr(4, 7); wr(5, 8'hFF);
        @(negedge clk); cpu_cycle = 1'b1; idle(20); cpu_cycle = 1'b0;
        check(irq == 1'b0, "R8 no irq while disabled", irq, 1'b0);
        // R10: offset 0 with bit0=1 enables
        wr(4, 7); wr(5, 8'hFF); wr(0, 1);
        run_count(1, "R10 offset0 enables");
        wr(2, 0);
        check(irq == 1'b0, "R10 offset2 clears", irq, 0);
        wr(4, 7); wr(5, 8'hFF);
        @(negedge clk); cpu_cycle = 1'b1; idle(10); cpu_cycle = 1'b0;
        check(irq == 1'b0, "R10 offset2 disables", irq, 0);

        // R1: stopped directions
        cfg(8'h04, 0, 7, 8'hFF);
        @(negedge clk); cpu_cycle = 1'b1; idle(30); cpu_cycle = 1'b0;
        check(irq == 1'b0, "R1 dir 00 stopped", irq, 0);
        wr(1, 8'hC4);
        @(negedge clk); cpu_cycle = 1'b1; idle(30); cpu_cycle = 1'b0;
        check(irq == 1'b0, "R1 dir 11 stopped", irq, 0);
        wr(1, 8'h44);
        run_count(1, "R1 values kept while stopped");

        // R5: write source gives no ticks
        cfg(8'h47, 0, 7, 8'hFF);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            cpu_cycle = 1'b1; scanline = k[0]; vaddr = 14'(k * 37);
        end
        @(negedge clk); cpu_cycle = 1'b0; scanline = 1'b0; vaddr = '0;
        idle(12);
        check(irq == 1'b0, "R5 reserved source silent", irq, 0);

        // R3: scanline burst of eight
        for (int pi = 0; pi < 2; pi++) begin
            int p = (pi == 0) ? 0 : 4;
            int e = exp_up(p, 8'hFF, 7);
            cfg(8'h45, 0, p, 8'hFF);
            @(negedge clk); scanline = 1'b1;
            @(posedge clk); @(negedge clk); scanline = 1'b0;
            first = 0;
            if (irq) first = -1;
            for (int k = 1; k <= 12; k++) begin
                @(posedge clk); @(negedge clk);
                if (irq && first == 0) first = k;
            end
            check(first == e, "R3 scanline burst timing", first, e);
        end
        // R3: one pulse gives only eight ticks (needs 16)
        cfg(8'h45, 0, 0, 8'hFE);
        @(negedge clk); scanline = 1'b1;
        @(negedge clk); scanline = 1'b0;
        idle(20);
        check(irq == 1'b0, "R3 eight ticks only", irq, 0);

        // R4: address changes, two ticks each; need 8 ticks
        cfg(8'h46, 0, 0, 8'hFF);
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk); vaddr = 14'(i * 5);
            idle(6);
        end
        idle(20);
        check(irq == 1'b0, "R4 six ticks after three changes", irq, 0);
        @(negedge clk); vaddr = 14'h3FFF;
        idle(6);
        check(irq == 1'b1, "R4 fourth change reaches wrap", irq, 1);
        cfg(8'h46, 0, 6, 8'hFF);
        idle(20);
        check(irq == 1'b0, "R4 steady address no ticks", irq, 0);
        @(negedge clk); vaddr = 14'h0001;
        @(posedge clk); @(negedge clk);
        first = 0;
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk); @(negedge clk);
            if (irq && first == 0) first = k;
        end
        check(first == 2, "R4 two ticks per change", first, 2);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule